// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block moves data words between two unrelated clock domains. The producer side writes one word on every write-clock edge where `wen_n` is low and the FIFO is not full. The consumer side takes one word on every read-clock edge where `ren_n` is low and a word is available. Read and write pointers cross between the domains as Gray code through two-flop synchronizers. Each side works out its own view of the fill level from its local pointer and the synchronized copy of the other side's pointer.

Four active-low level flags are derived from these views. Full, almost-full and half-full belong to the write domain. Almost-empty belongs to the read domain. The almost-full distance `m` and the almost-empty distance `n` are static inputs.

A mode input picks one of two read styles. In standard mode, a read loads the next word into the output register on the read edge. In fall-through mode, the oldest word is placed in the output register without any request, and a read consumes it. The output register then counts as one extra storage place. This raises the capacity by one word and moves the almost-empty and half-full thresholds up by one word. The mode and both distances are held steady while out of reset.

Top module: `dcfifo_flags`

## Requirements
- R1: Words leave in the order they were accepted. The capacity D is 2^AW words in standard mode (`fwft`=0) and 2^AW+1 words in fall-through mode (`fwft`=1).
- R2: `full_n` is low exactly when D words are held. A write attempted while `full_n` is low is ignored, so no stored word is lost or altered.
- R3: Standard mode: `avail` is high when at least one word is held. A read with `ren_n` low and `avail` high places the oldest word on `dout` at that read edge. A read attempted while `avail` is low is ignored.
- R4: Fall-through mode: when `avail` is high, the oldest word is already on `dout` with no read request. A read with `ren_n` low consumes it. While `ren_n` stays high, `dout` and `avail` hold.
- R5: `paf_n` is low when the level is at least D−m, where m is `af_off`. It is high when the level is D−m−1 or less. A write that reaches the threshold drives it low at that same write edge.
- R6: `pae_n` is low when the level is at most n+`fwft`, where n is `ae_off`. It is high when the level exceeds that. A read that reaches the threshold drives it low at that same read edge.
- R7: `hf_n` is low when the level is at least 2^(AW−1)+1+`fwft`. It is high below that. It is updated on write edges.
- R8: Changes coming from the other domain reach each flag within three edges of the flag's own clock. This covers `pae_n` clearing and `avail` rising after a write, and `paf_n` clearing after a read.
- R9: Each cross-domain pointer changes at most one bit per edge of its own clock.
- R10: During and right after reset, the FIFO is empty. `full_n`, `paf_n` and `hf_n` are high, `pae_n` is low, `avail` is low and `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft | input | 1 | 1 selects fall-through read mode, 0 selects standard mode |
| af_off | input | AW | Almost-full distance m |
| ae_off | input | AW | Almost-empty distance n |
| wen_n | input | 1 | Active-low write enable |
| din | input | DW | Write data |
| full_n | output | 1 | Low when full |
| paf_n | output | 1 | Low when almost full |
| hf_n | output | 1 | Low when more than half full |
| ren_n | input | 1 | Active-low read enable |
| dout | output | DW | Read data register |
| avail | output | 1 | A word can be read (standard) or `dout` is valid (fall-through) |
| pae_n | output | 1 | Low when almost empty |

## Verification
A flag driven by its own domain's activity (a write on `full_n`, `paf_n` and `hf_n`, or a read on `pae_n` and `avail`) must follow at that same edge. The bench therefore checks it at the next falling edge of that clock. Relief coming from the other domain is only due within three edges of the flag's clock. During traffic, the bench checks only the safe side: a flag must be asserted whenever the true level demands it, and deassertion is allowed to lag. Exact flag values are compared only after both clocks have idled for eight edges. In separate directed steps, the bench counts exactly three destination edges after a single crossing event and then requires the flag to have cleared.

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic [AW-1:0] af_off,
  input  logic [AW-1:0] ae_off,
  input  logic          wen_n,
  input  logic [DW-1:0] din,
  output logic          full_n,
  output logic          paf_n,
  output logic          hf_n,
  input  logic          ren_n,
  output logic [DW-1:0] dout,
  output logic          avail,
  output logic          pae_n
);
  localparam int PW    = AW + 1;
  localparam int SLOTS = 1 << AW;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [SLOTS];
  logic [PW-1:0] wbin, wgray, rbin, rgray, cbin, cgray;
  logic [PW-1:0] rg_w1, rg_w2, cg_w1, cg_w2, wg_r1, wg_r2;
  logic          ovalid;

  // write domain
  wire [PW-1:0] wlvl_arr = wbin - g2b(rg_w2);
  wire [PW-1:0] wlvl     = wbin - g2b(cg_w2);
  wire [PW-1:0] cap      = PW'(SLOTS) + PW'(fwft);
  wire          wr_go    = !wen_n && full_n;
  wire [PW-1:0] wbin_nx  = wbin + PW'(wr_go);

  assign full_n = (wlvl_arr != PW'(SLOTS));
  assign paf_n  = !(wlvl >= cap - PW'(af_off));
  assign hf_n   = !(wlvl >= PW'(SLOTS / 2 + 1) + PW'(fwft));

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_w1 <= '0;
      rg_w2 <= '0;
      cg_w1 <= '0;
      cg_w2 <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
      rg_w1 <= rgray;
      rg_w2 <= rg_w1;
      cg_w1 <= cgray;
      cg_w2 <= cg_w1;
    end

  // read domain
  wire [PW-1:0] wsb     = g2b(wg_r2);
  wire          arr_has = (wsb != rbin);
  assign avail = fwft ? ovalid : arr_has;
  wire          usr_rd  = !ren_n && avail;
  wire          pull    = fwft ? (arr_has && (!ovalid || usr_rd)) : usr_rd;
  wire [PW-1:0] rbin_nx = rbin + PW'(pull);
  wire [PW-1:0] cbin_nx = cbin + PW'(usr_rd);
  wire [PW-1:0] rlvl    = wsb - cbin;

  assign pae_n = !(rlvl <= PW'(ae_off) + PW'(fwft));

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      cbin   <= '0;
      cgray  <= '0;
      wg_r1  <= '0;
      wg_r2  <= '0;
      ovalid <= 1'b0;
      dout   <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      cbin  <= cbin_nx;
      cgray <= cbin_nx ^ (cbin_nx >> 1);
      wg_r1 <= wgray;
      wg_r2 <= wg_r1;
      if (pull) dout <= mem[rbin[AW-1:0]];
      if (!fwft)       ovalid <= 1'b0;
      else if (pull)   ovalid <= 1'b1;
      else if (usr_rd) ovalid <= 1'b0;
    end
endmodule

// File: rtl/dcfifo_flags_chk.sv
module dcfifo_flags_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          fwft,
  input logic          wen_n,
  input logic          ren_n,
  input logic          full_n,
  input logic          avail,
  input logic [AW:0]   wbin,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rgray,
  input logic [AW:0]   cbin,
  input logic [AW:0]   wlvl,
  input logic [DW-1:0] dout
);
  localparam int PW    = AW + 1;
  localparam int SLOTS = 1 << AW;

  // R2
  no_write_when_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n && !wen_n) |=> $stable(wbin));
  // R1
  level_cap_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wlvl <= PW'(SLOTS) + PW'(fwft));
  // R9
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R9
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  // R3
  no_read_when_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!avail && !ren_n) |=> $stable(cbin));
  // R4
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft && avail && ren_n) |=> ($stable(dout) && avail));
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft(fwft), .wen_n(wen_n),
  .ren_n(ren_n), .full_n(full_n), .avail(avail), .wbin(wbin), .wgray(wgray),
  .rgray(rgray), .cbin(cbin), .wlvl(wlvl), .dout(dout));

// File: tb/dcfifo_flags_tb.sv
module dcfifo_flags_tb;
  localparam int DW = 8, AW = 4, SLOTS = 1 << AW;
  localparam int WP = 10, RP = 14;

  logic wclk = 0, rclk = 0, rst_n = 0, fwft = 0;
  logic [AW-1:0] af_off = '0, ae_off = '0;
  logic wen_n = 1, ren_n = 1;
  logic [DW-1:0] din = '0;
  logic full_n, paf_n, hf_n, avail, pae_n;
  logic [DW-1:0] dout;

  dcfifo_flags #(.DW(DW), .AW(AW)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft(fwft), .af_off(af_off),
    .ae_off(ae_off), .wen_n(wen_n), .din(din), .full_n(full_n), .paf_n(paf_n),
    .hf_n(hf_n), .ren_n(ren_n), .dout(dout), .avail(avail), .pae_n(pae_n));

  always #(WP/2) wclk = ~wclk;
  initial begin #4; forever #(RP/2) rclk = ~rclk; end

  int checks = 0, errs = 0;
  logic [DW-1:0] q[$];
  bit active = 0, auto_w = 0, auto_r = 0, rd_pend = 0;
  int wprob = 0, rprob = 0, seed;
  logic [DW-1:0] rd_exp;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int cap_f();     return SLOTS + int'(fwft); endfunction
  function automatic int paf_thr();   return cap_f() - int'(af_off); endfunction
  function automatic int pae_thr();   return int'(ae_off) + int'(fwft); endfunction
  function automatic int hf_thr();    return SLOTS / 2 + 1 + int'(fwft); endfunction

  // write side: safe-side bounds, then random drive
  always @(negedge wclk) begin
    if (rst_n && active) begin
      if (q.size() >= paf_thr()) chk(paf_n == 1'b0, "R5 paf bound", paf_n, 0);
      if (q.size() >= hf_thr())  chk(hf_n == 1'b0, "R7 hf bound", hf_n, 0);
      if (q.size() == cap_f())   chk(full_n == 1'b0, "R2 full bound", full_n, 0);
    end
    if (auto_w) begin
      wen_n = 1;
      if ($urandom % 100 < wprob) begin
        din = DW'($urandom);
        wen_n = 0;
        if (full_n) q.push_back(din);
      end
    end
  end

  // read side: data and bound checks, then random drive
  always @(negedge rclk) begin
    if (rst_n && active) begin
      if (rd_pend) begin chk(dout == rd_exp, "R3 std data", dout, rd_exp); rd_pend = 0; end
      if (q.size() <= pae_thr()) chk(pae_n == 1'b0, "R6 pae bound", pae_n, 0);
      if (fwft && avail && q.size() > 0) chk(dout == q[0], "R4 fwft data", dout, q[0]);
    end
    if (auto_r) begin
      ren_n = 1;
      if ($urandom % 100 < rprob) begin
        ren_n = 0;
        if (avail) begin
          if (!fwft) begin rd_exp = q[0]; rd_pend = 1; end
          void'(q.pop_front());
        end
      end
    end
  end

  task automatic settle_exact(input string tag);
    int lv;
    repeat (8) @(posedge rclk);
    repeat (8) @(posedge wclk);
    lv = q.size();
    @(negedge wclk);
    chk(full_n == (lv < cap_f()), {tag, " R2 full_n"}, full_n, lv < cap_f());
    chk(paf_n == !(lv >= paf_thr()), {tag, " R5 paf_n"}, paf_n, !(lv >= paf_thr()));
    chk(hf_n == !(lv >= hf_thr()), {tag, " R7 hf_n"}, hf_n, !(lv >= hf_thr()));
    @(negedge rclk);
    chk(pae_n == !(lv <= pae_thr()), {tag, " R6 pae_n"}, pae_n, !(lv <= pae_thr()));
    chk(avail == (lv > 0), {tag, " R3 R4 avail"}, avail, lv > 0);
  endtask

  task automatic put();
    @(negedge wclk); #1;
    din = DW'($urandom);
    wen_n = 0;
    if (full_n) q.push_back(din);
    @(negedge wclk); #1;
    wen_n = 1;
  endtask

  task automatic take();
    logic [DW-1:0] e;
    bit got;
    @(negedge rclk); #1;
    got = avail;
    e = '0;
    if (got) begin
      if (fwft) chk(dout == q[0], "R4 fwft head", dout, q[0]);
      e = q.pop_front();
    end
    ren_n = 0;
    @(negedge rclk); #1;
    ren_n = 1;
    if (got && !fwft) chk(dout == e, "R1 R3 order", dout, e);
  endtask

  task automatic run(input bit mode, input int m, input int n);
    auto_w = 0; auto_r = 0; active = 0; rd_pend = 0;
    wen_n = 1; ren_n = 1;
    rst_n = 0;
    q.delete();
    fwft = mode; af_off = AW'(m); ae_off = AW'(n);
    repeat (3) @(posedge wclk);
    @(negedge rclk);
    // R10 reset values
    chk(full_n == 1 && paf_n == 1 && hf_n == 1, "R10 wr flags", {full_n, paf_n, hf_n}, 7);
    chk(pae_n == 0 && avail == 0 && dout == 0, "R10 rd side", {pae_n, avail}, 0);
    rst_n = 1;
    active = 1;
    settle_exact("reset");
    // fill beyond capacity
    for (int k = 0; k < cap_f() + 2; k++) begin
      put();
      if (q.size() == 1) begin
        @(posedge wclk);
        repeat (3) @(posedge rclk);
        @(negedge rclk);
        chk(avail == 1, "R8 avail latency", avail, 1);
      end
      if (q.size() == pae_thr() + 1 && k < cap_f()) begin
        @(posedge wclk);
        repeat (3) @(posedge rclk);
        @(negedge rclk);
        chk(pae_n == 1, "R8 pae clear latency", pae_n, 1);
      end
      settle_exact("fill");
    end
    chk(q.size() == cap_f(), "R1 R2 capacity", q.size(), cap_f());
    // drain below empty
    for (int k = 0; k < cap_f() + 1; k++) begin
      take();
      if (q.size() == paf_thr() - 1) begin
        repeat (3) @(posedge wclk);
        @(negedge wclk);
        chk(paf_n == 1, "R8 paf clear latency", paf_n, 1);
      end
      settle_exact("drain");
    end
    // random traffic
    auto_w = 1; auto_r = 1; wprob = 70; rprob = 40;
    repeat (1500) @(posedge wclk);
    wprob = 30; rprob = 70;
    repeat (1500) @(posedge wclk);
    auto_w = 0;
    @(negedge wclk); #1; wen_n = 1;
    rprob = 100;
    for (int k = 0; k < 200 && q.size() > 0; k++) @(posedge rclk);
    auto_r = 0;
    @(negedge rclk); #1; ren_n = 1;
    chk(q.size() == 0, "R1 drained", q.size(), 0);
    settle_exact("random");
  endtask

  initial begin
    seed = $urandom(32'd4711);
    run(1'b0, 3, 2);
    run(1'b1, 3, 2);
    run(1'b0, 0, 0);
    run(1'b1, 5, 7);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    #(WP * 150000);
    checks++;
    errs++;
    $display("FAIL R1 watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule